// File: doc/BRIEF.md
# Flash Lock-Bit Command Controller

This block is the command decoder and write-state sequencer for the protection bits of a NOR flash array. Each erase block has its own lock bit. A single permanent lock bit sits above all of them, and once it is set no block lock can be set or cleared again. The host sends bus write cycles made of a block address, a data byte and a one-cycle write strobe. Every change to a lock takes two cycles: a setup byte, then a confirm byte. One confirm locks the addressed block, another sets the permanent bit, and a third releases every block lock in the same cycle.

A confirmed operation holds the block busy for a configurable number of clock cycles. The ready/busy output and status bit 7 are low during that time. The result is applied in the last busy cycle. If the operation fails, no lock changes and a combination of status bits records the cause. After a setup byte the read port returns the status register, and it keeps doing so until another command selects the lock-read view. An operation in progress can be cut short by a warm reset. If that happens during a clear, the block locks are flagged unknown until a later clear completes. A separate power-on reset puts the nonvolatile lock state into a known, unlocked condition.

Top module: `lockCmdCtrl`

## Requirements
- R1: After power-on reset every block lock and the permanent lock read 0 and the lock state is known. Ready/busy is 1. The read port is in lock-read view and returns {5'b0, unknown, permanent, blockLock[busAddr]}, which is 00h here.
- R2: Writing 60h and then 01h sets the lock bit of the block whose index is on busAddr in the second cycle, and no other block's lock changes. A 01h, F1h or D0h written without a preceding 60h changes no lock bit and does not change the read view.
- R3: If 60h is followed by any byte other than 01h, F1h or D0h, status bits 5 and 4 are set, so the status reads B0h. No lock changes, and the block does not go busy.
- R4: When the permanent lock is set, a set-block operation fails and sets status bits 1 and 4 (92h once ready). A clear operation also fails and sets bits 1 and 5 (A2h once ready).
- R5: When vppOk is low at completion, a set operation sets bits 3 and 4 (98h) and a clear operation sets bits 3 and 5 (A8h). No lock bit changes in either case.
- R6: Writing 60h and then D0h, with vppOk high and the permanent lock clear, releases every block lock in a single cycle. It also marks the lock state known.
- R7: Writing 60h and then F1h with vppOk high sets the permanent lock. No command ever clears it.
- R8: After 60h the read port returns the status register {ready, 0, b5, b4, b3, 0, b1, 0}, and it stays in that view until FFh is written. FFh selects the lock-read view.
- R9: A confirmed operation holds ready/busy and status bit 7 at 0 for BUSY_CYC cycles after the confirm edge. During that time reads return the status register whatever the view.
- R10: Writes made while busy are ignored, including setup, confirm, FFh and 50h.
- R11: Error bits stay set through later commands until 50h is written while idle, and 50h does not change the read view. A warm reset also clears them.
- R12: A warm reset during a clear operation sets the unknown flag, which is bit 2 of the lock-read view, and leaves the block locks unchanged. The next successful clear drops the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous warm reset, active low; resets the sequencer and the status register |
| porN | input | 1 | Synchronous power-on reset, active low; also initialises the lock bits |
| vppOk | input | 1 | Programming voltage is within its valid range |
| wrEn | input | 1 | One-cycle write strobe |
| busAddr | input | BLK_W | Block index, used by writes and by the lock-read view |
| busData | input | 8 | Command byte |
| rdData | output | 8 | Status register or lock-read view |
| rdyBsy | output | 1 | 1 when ready, 0 while busy |

## Verification
The assertions assume that wrEn is a pulse driven between clock edges. They also assume that busAddr always names an existing block and that porN is pulsed before any lock is used. vppOk is sampled only in the completion cycle, so the checks on unchanged locks under low VPP assume it holds its level through the whole busy window. The stimulus drives every input on the falling edge, changes vppOk only while the block is idle, issues porN once at the start, and uses indices within the default eight blocks.

// File: rtl/lockCmdPkg.sv
package lockCmdPkg;
  localparam logic [7:0] CMD_SETUP    = 8'h60;
  localparam logic [7:0] CMD_SETBLK   = 8'h01;
  localparam logic [7:0] CMD_SETPERM  = 8'hF1;
  localparam logic [7:0] CMD_CLRALL   = 8'hD0;
  localparam logic [7:0] CMD_CLRSTAT  = 8'h50;
  localparam logic [7:0] CMD_LOCKREAD = 8'hFF;

  typedef enum logic [1:0] {
    OP_NONE,
    OP_SETBLK,
    OP_SETPERM,
    OP_CLRALL
  } lockOp_e;

  // strobes from sequencer to lock datapath
  typedef struct packed {
    logic    applyOp;     // last busy cycle: commit or fail current op
    lockOp_e op;          // operation being committed
    logic    badSeq;      // setup followed by an unknown confirm
    logic    clrStat;     // clear-status command accepted
    logic    resetInClr;  // warm reset arrived during a clear
  } ctrlStrb_t;
endpackage

// File: rtl/lockCtrl.sv
module lockCtrl
  import lockCmdPkg::*;
#(
  parameter int BLK_W    = 3,
  parameter int BUSY_CYC = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             porN,
  input  logic             wrEn,
  input  logic [7:0]       wrData,
  input  logic [BLK_W-1:0] wrBlk,
  output ctrlStrb_t        strb,
  output logic [BLK_W-1:0] opBlk,
  output logic             busy,
  output logic             statusMode
);
  localparam int CNT_W = $clog2(BUSY_CYC + 1);

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_BUSY} seqState_e;

  seqState_e  st;
  logic [CNT_W-1:0] cnt;
  lockOp_e    curOp;
  lockOp_e    confirmOp;
  logic       ctrlRst;

  assign ctrlRst = !rstN || !porN;

  always_comb begin
    unique case (wrData)
      CMD_SETBLK:  confirmOp = OP_SETBLK;
      CMD_SETPERM: confirmOp = OP_SETPERM;
      CMD_CLRALL:  confirmOp = OP_CLRALL;
      default:     confirmOp = OP_NONE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (ctrlRst) begin
      st         <= ST_IDLE;
      cnt        <= '0;
      curOp      <= OP_NONE;
      opBlk      <= '0;
      statusMode <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (wrEn) begin
            if (wrData == CMD_SETUP) begin
              st         <= ST_SETUP;
              statusMode <= 1'b1;
            end else if (wrData == CMD_LOCKREAD) begin
              statusMode <= 1'b0;
            end
          end
        end
        ST_SETUP: begin
          if (wrEn) begin
            statusMode <= 1'b1;
            if (confirmOp != OP_NONE) begin
              st    <= ST_BUSY;
              cnt   <= CNT_W'(BUSY_CYC);
              curOp <= confirmOp;
              opBlk <= wrBlk;
            end else begin
              st <= ST_IDLE;
            end
          end
        end
        ST_BUSY: begin
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) begin
            st    <= ST_IDLE;
            curOp <= OP_NONE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strb.applyOp    = rstN && porN && (st == ST_BUSY) && (cnt == CNT_W'(1));
    strb.op         = curOp;
    strb.badSeq     = rstN && porN && (st == ST_SETUP) && wrEn && (confirmOp == OP_NONE);
    strb.clrStat    = rstN && porN && (st == ST_IDLE) && wrEn && (wrData == CMD_CLRSTAT);
    strb.resetInClr = !rstN && porN && (st == ST_BUSY) && (curOp == OP_CLRALL);
  end

  assign busy = (st == ST_BUSY);

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (ctrlRst)
    (busy && cnt != CNT_W'(1)) |=> busy);  // R10

  AST_ONE_ACTION: assert property (@(posedge clk) disable iff (ctrlRst)
    $onehot0({strb.applyOp, strb.badSeq, strb.clrStat}));  // R3

  AST_STATUS_AFTER_SETUP: assert property (@(posedge clk) disable iff (ctrlRst)
    (st == ST_IDLE && wrEn && wrData == CMD_SETUP) |=> statusMode);  // R8

  AST_BUSY_WINDOW: assert property (@(posedge clk) disable iff (ctrlRst)
    (st == ST_SETUP && wrEn && confirmOp != OP_NONE) |=> (busy && cnt == CNT_W'(BUSY_CYC)));  // R9
endmodule

// File: rtl/lockData.sv
module lockData
  import lockCmdPkg::*;
#(
  parameter int BLK_CNT = 8,
  parameter int BLK_W   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             porN,
  input  logic             vppOk,
  input  ctrlStrb_t        strb,
  input  logic [BLK_W-1:0] opBlk,
  input  logic [BLK_W-1:0] rdBlk,
  input  logic             busy,
  input  logic             statusMode,
  output logic [7:0]       rdData
);
  logic [BLK_CNT-1:0] blkLock;
  logic permLock;
  logic lockUnknown;
  logic errPerm, errVpp, errSet, errClr;
  logic vppFail, permFail, opFail, isClr;
  logic [7:0] statusByte, lockByte;

  assign vppFail  = !vppOk;
  assign permFail = vppOk && permLock && (strb.op != OP_SETPERM);
  assign opFail   = vppFail || permFail;
  assign isClr    = (strb.op == OP_CLRALL);

  // nonvolatile lock state: only power-on reset initialises it
  always_ff @(posedge clk) begin
    if (!porN) begin
      blkLock     <= '0;
      permLock    <= 1'b0;
      lockUnknown <= 1'b0;
    end else if (strb.resetInClr) begin
      lockUnknown <= 1'b1;
    end else if (strb.applyOp && !opFail) begin
      unique case (strb.op)
        OP_SETBLK:  blkLock[opBlk] <= 1'b1;
        OP_SETPERM: permLock <= 1'b1;
        OP_CLRALL: begin
          blkLock     <= '0;
          lockUnknown <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN || !porN || strb.clrStat) begin
      errPerm <= 1'b0;
      errVpp  <= 1'b0;
      errSet  <= 1'b0;
      errClr  <= 1'b0;
    end else begin
      if (strb.badSeq) begin
        errSet <= 1'b1;
        errClr <= 1'b1;
      end
      if (strb.applyOp && opFail) begin
        if (vppFail)  errVpp  <= 1'b1;
        if (permFail) errPerm <= 1'b1;
        if (isClr) errClr <= 1'b1;
        else       errSet <= 1'b1;
      end
    end
  end

  assign statusByte = {!busy, 1'b0, errClr, errSet, errVpp, 1'b0, errPerm, 1'b0};
  assign lockByte   = {5'b0, lockUnknown, permLock, blkLock[rdBlk]};
  assign rdData     = (busy || statusMode) ? statusByte : lockByte;

  AST_PERM_STICKY: assert property (@(posedge clk) disable iff (!porN)
    permLock |=> permLock);  // R7

  AST_LOCKS_HOLD: assert property (@(posedge clk) disable iff (!porN)
    !strb.applyOp |=> $stable(blkLock));  // R2

  AST_NO_VPP_NO_CHANGE: assert property (@(posedge clk) disable iff (!porN)
    (strb.applyOp && !vppOk) |=> ($stable(blkLock) && $stable(permLock)));  // R5

  AST_CLEAR_PARALLEL: assert property (@(posedge clk) disable iff (!porN)
    (strb.applyOp && strb.op == OP_CLRALL && vppOk && !permLock) |=> (blkLock == '0 && !lockUnknown));  // R6

  AST_PERM_BLOCKS_SET: assert property (@(posedge clk) disable iff (!porN)
    (strb.applyOp && permLock && strb.op != OP_SETPERM) |=> $stable(blkLock));  // R4
endmodule

// File: rtl/lockCmdCtrl.sv
module lockCmdCtrl
  import lockCmdPkg::*;
#(
  parameter int BLK_CNT  = 8,
  parameter int BUSY_CYC = 4,
  localparam int BLK_W   = (BLK_CNT > 1) ? $clog2(BLK_CNT) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             porN,
  input  logic             vppOk,
  input  logic             wrEn,
  input  logic [BLK_W-1:0] busAddr,
  input  logic [7:0]       busData,
  output logic [7:0]       rdData,
  output logic             rdyBsy
);
  ctrlStrb_t        strb;
  logic [BLK_W-1:0] opBlk;
  logic             busy;
  logic             statusMode;

  lockCtrl #(.BLK_W(BLK_W), .BUSY_CYC(BUSY_CYC)) uCtrl (
    .clk(clk), .rstN(rstN), .porN(porN), .wrEn(wrEn), .wrData(busData),
    .wrBlk(busAddr), .strb(strb), .opBlk(opBlk), .busy(busy),
    .statusMode(statusMode)
  );

  lockData #(.BLK_CNT(BLK_CNT), .BLK_W(BLK_W)) uData (
    .clk(clk), .rstN(rstN), .porN(porN), .vppOk(vppOk), .strb(strb),
    .opBlk(opBlk), .rdBlk(busAddr), .busy(busy), .statusMode(statusMode),
    .rdData(rdData)
  );

  assign rdyBsy = !busy;
endmodule

// File: tb/lockCmdCtrl_test.sv
module lockCmdCtrl_test;
  localparam int BLKS = 8;
  localparam int BUSY = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0, porN = 1'b0, vppOk = 1'b1, wrEn = 1'b0;
  logic [2:0] busAddr = '0;
  logic [7:0] busData = '0;
  logic [7:0] rdData;
  logic rdyBsy;

  int checks = 0, fails = 0;
  bit cmpOn = 0, done = 0;

  // behavioural reference state
  bit mLocks[BLKS];
  bit mPerm, mUnknown, mSetup, mStat;
  bit e1, e3, e4, e5;
  int mBusyLeft = 0;
  int mOp = 0;      // 1 set block, 2 set permanent, 3 clear all
  int mBlk = 0;

  lockCmdCtrl #(.BLK_CNT(BLKS), .BUSY_CYC(BUSY)) uut (
    .clk(clk), .rstN(rstN), .porN(porN), .vppOk(vppOk), .wrEn(wrEn),
    .busAddr(busAddr), .busData(busData), .rdData(rdData), .rdyBsy(rdyBsy)
  );

  always #10 clk = ~clk;

  task automatic applyModelOp();
    if (!vppOk) begin
      e3 = 1;
      if (mOp == 3) e5 = 1; else e4 = 1;
    end else if (mOp == 2) begin
      mPerm = 1;
    end else if (mPerm) begin
      e1 = 1;
      if (mOp == 3) e5 = 1; else e4 = 1;
    end else if (mOp == 1) begin
      mLocks[mBlk] = 1;
    end else begin
      foreach (mLocks[i]) mLocks[i] = 0;
      mUnknown = 0;
    end
  endtask

  always @(posedge clk) begin
    if (!porN) begin
      foreach (mLocks[i]) mLocks[i] = 0;
      mPerm = 0; mUnknown = 0;
    end
    if (!porN || !rstN) begin
      if (porN && mBusyLeft > 0 && mOp == 3) mUnknown = 1;
      mBusyLeft = 0; mSetup = 0; mStat = 0;
      e1 = 0; e3 = 0; e4 = 0; e5 = 0;
    end else if (mBusyLeft > 0) begin
      mBusyLeft--;
      if (mBusyLeft == 0) applyModelOp();
    end else if (wrEn) begin
      if (mSetup) begin
        mSetup = 0; mStat = 1;
        if (busData == 8'h01 || busData == 8'hF1 || busData == 8'hD0) begin
          mOp = (busData == 8'h01) ? 1 : (busData == 8'hF1) ? 2 : 3;
          mBlk = int'(busAddr);
          mBusyLeft = BUSY;
        end else begin
          e4 = 1; e5 = 1;
        end
      end else if (busData == 8'h60) begin
        mSetup = 1; mStat = 1;
      end else if (busData == 8'h50) begin
        e1 = 0; e3 = 0; e4 = 0; e5 = 0;
      end else if (busData == 8'hFF) begin
        mStat = 0;
      end
    end
  end

  function automatic logic [7:0] modelRd();
    bit rdy;
    rdy = (mBusyLeft == 0);
    if (!rdy || mStat) return {rdy, 1'b0, e5, e4, e3, 1'b0, e1, 1'b0};
    return {5'b0, mUnknown, mPerm, mLocks[busAddr]};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    #5;
    if (cmpOn && !done) begin
      chk("R8 model read", rdData, modelRd());
      chk("R9 model ready", {7'b0, rdyBsy}, {7'b0, mBusyLeft == 0});
    end
  end

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    busAddr = a; busData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic peek(string tag, logic [7:0] exp);
    #2 chk(tag, rdData, exp);
  endtask

  task automatic look(logic [2:0] a, string tag, logic [7:0] exp);
    @(negedge clk);
    busAddr = a;
    #2 chk(tag, rdData, exp);
  endtask

  task automatic waitDone();
    repeat (BUSY) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(20 * 100000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    porN = 1'b1; rstN = 1'b1;
    cmpOn = 1;
    // R1 reset state
    look(0, "R1 lock view after reset", 8'h00);
    chk("R1 ready after reset", {7'b0, rdyBsy}, 8'h01);
    // R2 lone confirm ignored
    wr(3, 8'h01);
    look(3, "R2 lone confirm", 8'h00);
    wr(3, 8'hD0);
    look(3, "R2 lone clear", 8'h00);
    // R2 set block 3, R8 status view, R9 busy
    wr(3, 8'h60);
    peek("R8 status after setup", 8'h80);
    wr(3, 8'h01);
    peek("R9 busy status", 8'h00);
    chk("R9 busy pin", {7'b0, rdyBsy}, 8'h00);
    waitDone();
    peek("R9 ready again", 8'h80);
    wr(0, 8'hFF);
    look(3, "R2 block 3 locked", 8'h01);
    look(2, "R2 block 2 untouched", 8'h00);
    // R3 invalid confirm, R11 sticky
    wr(0, 8'h60);
    wr(0, 8'h77);
    peek("R3 invalid sequence", 8'hB0);
    chk("R3 not busy", {7'b0, rdyBsy}, 8'h01);
    wr(0, 8'h01);
    peek("R11 errors sticky", 8'hB0);
    wr(0, 8'h50);
    peek("R11 clear status", 8'h80);
    wr(0, 8'hFF);
    look(3, "R3 lock unchanged", 8'h01);
    // R10 writes while busy
    wr(5, 8'h60);
    wr(5, 8'h01);
    wr(6, 8'h60);
    wr(6, 8'h01);
    waitDone();
    peek("R10 status after busy", 8'h80);
    wr(0, 8'hFF);
    look(6, "R10 busy write ignored", 8'h00);
    look(5, "R2 block 5 locked", 8'h01);
    // R5 low VPP
    vppOk = 1'b0;
    wr(1, 8'h60);
    wr(1, 8'h01);
    waitDone();
    peek("R5 set with low vpp", 8'h98);
    wr(0, 8'h50);
    wr(0, 8'h60);
    wr(0, 8'hD0);
    waitDone();
    peek("R5 clear with low vpp", 8'hA8);
    wr(0, 8'h50);
    wr(0, 8'hFF);
    look(3, "R5 locks kept", 8'h01);
    look(1, "R5 block 1 not set", 8'h00);
    vppOk = 1'b1;
    // R6 clear all
    wr(0, 8'h60);
    wr(0, 8'hD0);
    waitDone();
    wr(0, 8'hFF);
    look(3, "R6 block 3 cleared", 8'h00);
    look(5, "R6 block 5 cleared", 8'h00);
    // R12 reset during clear
    wr(2, 8'h60);
    wr(2, 8'h01);
    waitDone();
    wr(0, 8'h60);
    wr(0, 8'hD0);
    rstN = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    look(2, "R12 unknown after reset", 8'h05);
    wr(0, 8'h60);
    wr(0, 8'hD0);
    waitDone();
    wr(0, 8'hFF);
    look(2, "R12 known after clear", 8'h00);
    // R7 / R4 permanent lock
    wr(4, 8'h60);
    wr(4, 8'h01);
    waitDone();
    wr(0, 8'h60);
    wr(0, 8'hF1);
    waitDone();
    wr(0, 8'hFF);
    look(4, "R7 permanent set", 8'h03);
    wr(1, 8'h60);
    wr(1, 8'h01);
    waitDone();
    peek("R4 set under permanent", 8'h92);
    wr(0, 8'h50);
    wr(0, 8'h60);
    wr(0, 8'hD0);
    waitDone();
    peek("R4 clear under permanent", 8'hA2);
    wr(0, 8'h50);
    wr(0, 8'hFF);
    look(4, "R7 permanent kept", 8'h03);
    look(1, "R4 block 1 not set", 8'h02);
    repeat (3) @(negedge clk);
    finishRun();
  end
endmodule